// File: doc/BRIEF.md
# Serial Audio Input Port

This block receives stereo PCM audio over a three-wire serial link made of a bit clock, a word-rate clock and a data line. It produces one channel A (left) and one channel B (right) sample per frame as 24-bit parallel words, together with a one-cycle valid strobe. Everything runs on a single system clock. The serial clock and data pins are oversampled through two-flop synchronizers. Bit-clock edges are then detected from the synchronized copies.

Static configuration inputs set the framing:
- left-justified or right-justified alignment;
- an optional one-bit delay after each word-clock change (I2S is left-justified with this delay and the word clock inverted);
- which bit-clock edge samples the data;
- which word-clock level marks channel A;
- a two-bit word length used by right-justified framing.

In master mode the port divides the system clock to make its own bit clock, at 64 bit periods per frame. It drives that bit clock and a matching word clock out, and it flags that it is driving them.

Top module: `sai_rx_port`

## Requirements
- R1: While reset is high and in the cycle after it, valid_o, left_o, right_o, bclk_o, wclk_o and clk_drive_o are all zero.
- R2: With cfg_rjust=0 and cfg_delay=0, the data bit sampled at the first sampling edge after a word-clock change is the MSB (bit 23) of that channel's word. The next 23 bits follow MSB first. Any bits after the 24th in the same half-frame are ignored.
- R3: With cfg_delay=1 in left-justified framing, the first bit after a word-clock change is ignored and the MSB is taken from the second bit.
- R4: With cfg_wclk_inv=0, a high word clock marks channel A. With cfg_wclk_inv=1, a low word clock marks channel A. Channel A's word appears on left_o and channel B's word on right_o.
- R5: With cfg_bclk_fall=0, data and word clock are sampled on rising bit-clock edges. With cfg_bclk_fall=1, they are sampled on falling edges.
- R6: With cfg_rjust=1, the word is the last N bits before the next word-clock change, LSB last. cfg_res 00 gives N=24, 01 gives N=20, 10 gives N=16 and 11 gives N=24. Earlier bits are ignored. The N bits fill the top of the 24-bit output and the unused low bits are zero.
- R7: In left-justified framing the cfg_res field has no effect: all 24 bits are captured.
- R8: valid_o is a single-cycle pulse raised once per frame, after a channel B half-frame ends. left_o and right_o change only in that cycle and hold their values between pulses.
- R9: A pair is delivered only after a word-clock change has been seen and then a full channel A half-frame followed by a channel B half-frame has been received. The partial half-frame in progress at reset is discarded.
- R10: With cfg_master=1, bclk_o toggles every BCLK_HALF system clocks. wclk_o changes only together with a launch (non-sampling) bit-clock edge, and it stays at each level for 32 bit periods. clk_drive_o is high.
- R11: With cfg_master=0, clk_drive_o is low, bclk_o and wclk_o stay low, and the port captures from bclk_i and wclk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: port generates bit and word clocks |
| cfg_rjust | input | 1 | 1: right-justified framing |
| cfg_delay | input | 1 | 1: skip one bit after word-clock change |
| cfg_res | input | 2 | Right-justified word length select |
| cfg_bclk_fall | input | 1 | 1: sample on falling bit-clock edge |
| cfg_wclk_inv | input | 1 | 1: low word clock marks channel A |
| bclk_i | input | 1 | Bit clock from the pin (slave) |
| wclk_i | input | 1 | Word clock from the pin (slave) |
| sdata_i | input | 1 | Serial data |
| bclk_o | output | 1 | Generated bit clock (master) |
| wclk_o | output | 1 | Generated word clock (master) |
| clk_drive_o | output | 1 | High when the clock outputs are driven |
| left_o | output | 24 | Channel A word |
| right_o | output | 24 | Channel B word |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
The slave path is swept over every framing combination. This covers left-justified with and without delay, inverted word clock, falling-edge sampling, and right-justified at all four resolution codes. Every bit the receiver must ignore (the delay slot, bits past the 24th, bits ahead of the right-justified MSB) is driven as a one. As a result, a stray capture shows up as a wrong word rather than passing unseen. Each run starts mid-way through a channel B half-frame and ends partway into a channel A half-frame, so that the pair count separates correct discard of partial halves from off-by-one framing. Master mode is checked by timing the generated clocks and by capturing data the bench serializes against them.

// File: rtl/sai_pkg.sv
package sai_pkg;
  localparam int WORD_W = 24;

  typedef enum logic [1:0] {
    RES_W24  = 2'b00,
    RES_W20  = 2'b01,
    RES_W16  = 2'b10,
    RES_W24X = 2'b11
  } res_e;

  function automatic int res_shift(input logic [1:0] res);
    case (res)
      RES_W20: return 4;
      RES_W16: return 8;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/sai_pin_sync.sv
module sai_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= '0;
          else     stage[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= '0;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sai_clk_gen.sv
module sai_clk_gen #(
  parameter int BCLK_HALF  = 2,
  parameter int FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic launch_lvl,
  input  logic a_lvl,
  output logic bclk,
  output logic wclk
);
  localparam int DIV_W  = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
  localparam int SLOT_W = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BCLK_HALF - 1);

  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_nx;

  assign slot_nx = slot_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_q  <= '0;
      slot_q <= '0;
      bclk   <= 1'b0;
      wclk   <= 1'b0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      bclk  <= ~bclk;
      if (~bclk == launch_lvl) begin
        slot_q <= slot_nx;
        wclk   <= slot_nx[SLOT_W-1] ? ~a_lvl : a_lvl;
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/sai_deser.sv
module sai_deser
  import sai_pkg::*;
#(
  parameter int FRAME_BITS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_bclk,
  input  logic              s_wclk,
  input  logic              s_data,
  input  logic              cfg_rjust,
  input  logic              cfg_delay,
  input  logic [1:0]        cfg_res,
  input  logic              cfg_bclk_fall,
  input  logic              cfg_wclk_inv,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  localparam int IDX_W   = $clog2(FRAME_BITS);
  localparam int IDX_MAX = (1 << IDX_W) - 1;

  logic              bclk_prev;
  logic              samp_edge;
  logic              ch_a;
  logic              primed, started, a_seen, prev_a;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] lj_q, rj_q, a_hold;
  logic              trans;
  logic [WORD_W-1:0] lj_nx, rj_nx, done_word;
  logic [IDX_W-1:0]  idx_nx;

  // sampling edge: bit clock moves from the launch level to the sampling level
  assign samp_edge = (s_bclk != bclk_prev) && (s_bclk == ~cfg_bclk_fall);
  assign ch_a      = s_wclk ^ cfg_wclk_inv;
  assign trans     = primed && (ch_a != prev_a);

  always_comb begin
    int k;
    int p;
    k         = trans ? 0 : int'(idx_q);
    p         = k - int'(cfg_delay);
    lj_nx     = trans ? '0 : lj_q;
    if (p >= 0 && p < WORD_W) lj_nx[WORD_W-1-p] = s_data;
    rj_nx     = trans ? {{(WORD_W-1){1'b0}}, s_data} : {rj_q[WORD_W-2:0], s_data};
    done_word = cfg_rjust ? (rj_q << res_shift(cfg_res)) : lj_q;
    if (trans)                      idx_nx = IDX_W'(1);
    else if (int'(idx_q) < IDX_MAX) idx_nx = idx_q + 1'b1;
    else                            idx_nx = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_prev <= 1'b0;
      primed    <= 1'b0;
      started   <= 1'b0;
      a_seen    <= 1'b0;
      prev_a    <= 1'b0;
      idx_q     <= '0;
      lj_q      <= '0;
      rj_q      <= '0;
      a_hold    <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      bclk_prev <= s_bclk;
      valid_o   <= 1'b0;
      if (samp_edge) begin
        primed <= 1'b1;
        prev_a <= ch_a;
        idx_q  <= idx_nx;
        lj_q   <= lj_nx;
        rj_q   <= rj_nx;
        if (trans) begin
          started <= 1'b1;
          if (started && prev_a) begin
            a_hold <= done_word;
            a_seen <= 1'b1;
          end
          if (started && !prev_a && a_seen) begin
            left_o  <= a_hold;
            right_o <= done_word;
            valid_o <= 1'b1;
            a_seen  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sai_rx_port.sv
module sai_rx_port
  import sai_pkg::*;
#(
  parameter int BCLK_HALF   = 2,
  parameter int FRAME_BITS  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic              cfg_rjust,
  input  logic              cfg_delay,
  input  logic [1:0]        cfg_res,
  input  logic              cfg_bclk_fall,
  input  logic              cfg_wclk_inv,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  output logic              bclk_o,
  output logic              wclk_o,
  output logic              clk_drive_o,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic       gen_bclk, gen_wclk;
  logic [2:0] raw_pins, sync_pins;

  sai_clk_gen #(.BCLK_HALF(BCLK_HALF), .FRAME_BITS(FRAME_BITS)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_master),
    .launch_lvl(cfg_bclk_fall),
    .a_lvl     (~cfg_wclk_inv),
    .bclk      (gen_bclk),
    .wclk      (gen_wclk)
  );

  assign raw_pins = cfg_master ? {gen_bclk, gen_wclk, sdata_i}
                               : {bclk_i, wclk_i, sdata_i};

  sai_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_pins), .q(sync_pins)
  );

  sai_deser #(.FRAME_BITS(FRAME_BITS)) u_deser (
    .clk          (clk),
    .rst          (rst),
    .s_bclk       (sync_pins[2]),
    .s_wclk       (sync_pins[1]),
    .s_data       (sync_pins[0]),
    .cfg_rjust    (cfg_rjust),
    .cfg_delay    (cfg_delay),
    .cfg_res      (cfg_res),
    .cfg_bclk_fall(cfg_bclk_fall),
    .cfg_wclk_inv (cfg_wclk_inv),
    .left_o       (left_o),
    .right_o      (right_o),
    .valid_o      (valid_o)
  );

  assign bclk_o = gen_bclk;
  assign wclk_o = gen_wclk;

  always_ff @(posedge clk) begin
    if (rst) clk_drive_o <= 1'b0;
    else     clk_drive_o <= cfg_master;
  end
endmodule

// File: rtl/sai_rx_port_chk.sv
module sai_rx_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_master,
  input logic        cfg_rjust,
  input logic [1:0]  cfg_res,
  input logic        bclk_o,
  input logic        wclk_o,
  input logic        clk_drive_o,
  input logic [23:0] left_o,
  input logic [23:0] right_o,
  input logic        valid_o
);
  // R8: strobe lasts one cycle
  p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R8: words move only with the strobe
  p_words_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R6: 16-bit right-justified words carry zero low byte
  p_zero_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && cfg_rjust && cfg_res == 2'b10) |-> (left_o[7:0] == 8'h00 && right_o[7:0] == 8'h00));

  // R10: generated bit clock holds each level at least two cycles
  p_bclk_half_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && $past(cfg_master) && $changed(bclk_o)) |=> $stable(bclk_o));

  // R10: word clock moves only with a bit-clock edge
  p_wclk_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && $past(cfg_master) && $changed(wclk_o)) |-> $changed(bclk_o));

  // R11: slave mode leaves the clock outputs quiet
  p_slave_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!cfg_master && !$past(cfg_master)) |=> (!bclk_o && !wclk_o && !clk_drive_o));
endmodule

bind sai_rx_port sai_rx_port_chk u_chk (
  .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_rjust(cfg_rjust),
  .cfg_res(cfg_res), .bclk_o(bclk_o), .wclk_o(wclk_o), .clk_drive_o(clk_drive_o),
  .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
);

// File: tb/sai_rx_port_tb.sv
module sai_rx_port_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        cfg_master = 0, cfg_rjust = 0, cfg_delay = 0, cfg_bclk_fall = 0, cfg_wclk_inv = 0;
  logic [1:0]  cfg_res = 2'b00;
  logic        bclk_i = 0, wclk_i = 0, sdata_i = 0;
  logic        bclk_o, wclk_o, clk_drive_o, valid_o;
  logic [23:0] left_o, right_o;

  sai_rx_port u_dut (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_rjust(cfg_rjust),
    .cfg_delay(cfg_delay), .cfg_res(cfg_res), .cfg_bclk_fall(cfg_bclk_fall),
    .cfg_wclk_inv(cfg_wclk_inv), .bclk_i(bclk_i), .wclk_i(wclk_i), .sdata_i(sdata_i),
    .bclk_o(bclk_o), .wclk_o(wclk_o), .clk_drive_o(clk_drive_o),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ncap  = 0;
  logic [23:0] cap_l [8];
  logic [23:0] cap_r [8];
  logic [23:0] exp_l [8];
  logic [23:0] exp_r [8];

  always @(negedge clk) begin
    if (!rst && valid_o && ncap < 8) begin
      cap_l[ncap] = left_o;
      cap_r[ncap] = right_o;
      ncap = ncap + 1;
    end
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd = wd + 1;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    ncap = 0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_slot(input logic wl, input logic d);
    bclk_i  = cfg_bclk_fall;
    wclk_i  = wl;
    sdata_i = d;
    repeat (2) @(negedge clk);
    bclk_i = ~cfg_bclk_fall;
    repeat (2) @(negedge clk);
  endtask

  function automatic int rj_bits(input logic [1:0] r);
    return (r == 2'b01) ? 20 : (r == 2'b10) ? 16 : 24;
  endfunction

  task automatic send_half(input logic is_a, input logic [23:0] w);
    logic wl;
    wl = is_a ? ~cfg_wclk_inv : cfg_wclk_inv;
    for (int i = 0; i < 32; i++) begin
      logic b;
      if (cfg_rjust) begin
        int j;
        j = 31 - i;
        b = (j < rj_bits(cfg_res)) ? w[j] : 1'b1;
      end else begin
        int k;
        k = i - int'(cfg_delay);
        b = (k >= 0 && k < 24) ? w[23-k] : 1'b1;
      end
      send_slot(wl, b);
    end
  endtask

  function automatic logic [23:0] expect_word(input logic [23:0] w);
    int n;
    if (!cfg_rjust) return w;
    n = rj_bits(cfg_res);
    return (w << (24 - n));
  endfunction

  task automatic run_slave(input string req, input int seed, input logic rj, input logic dl,
                           input logic [1:0] res, input logic fall, input logic inv);
    cfg_master = 0; cfg_rjust = rj; cfg_delay = dl; cfg_res = res;
    cfg_bclk_fall = fall; cfg_wclk_inv = inv;
    bclk_i = fall; wclk_i = 0; sdata_i = 0;
    do_reset();
    for (int i = 0; i < 5; i++) send_slot(inv, 1'b1);   // partial channel B lead-in
    for (int f = 0; f < 3; f++) begin
      logic [23:0] wa, wb;
      wa = 24'(seed * 24'h2F1D3 + f * 24'h9E3779) ^ 24'hA5C3F1;
      wb = ~wa ^ 24'(f * 24'h010203 + seed);
      exp_l[f] = expect_word(wa);
      exp_r[f] = expect_word(wb);
      send_half(1'b1, wa);
      send_half(1'b0, wb);
    end
    for (int i = 0; i < 4; i++) send_slot(~inv, 1'b1);  // partial channel A tail
    repeat (12) @(negedge clk);
    check({req, " R9 pair count"}, 24'(ncap), 24'd3);
    for (int f = 0; f < 3; f++) begin
      check({req, " R8 left"},  cap_l[f], exp_l[f]);
      check({req, " R8 right"}, cap_r[f], exp_r[f]);
    end
  endtask

  initial begin
    logic [23:0] ma, mb;
    int t0, per, nb, slot;
    logic pw, pb;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 valid", 24'(valid_o), 24'd0);
    check("R1 left", left_o, 24'd0);
    check("R1 right", right_o, 24'd0);
    check("R1 clocks", {21'd0, bclk_o, wclk_o, clk_drive_o}, 24'd0);
    rst = 1'b0;

    run_slave("R2 left-justified", 1, 0, 0, 2'b00, 0, 0);
    run_slave("R3 delayed", 2, 0, 1, 2'b00, 0, 1);
    run_slave("R4 inverted wclk", 3, 0, 0, 2'b00, 0, 1);
    run_slave("R5 falling edge", 4, 0, 1, 2'b00, 1, 0);
    run_slave("R6 rj24", 5, 1, 0, 2'b00, 0, 0);
    run_slave("R6 rj20", 6, 1, 0, 2'b01, 0, 0);
    run_slave("R6 rj16", 7, 1, 1, 2'b10, 1, 1);
    run_slave("R6 rj24 code3", 8, 1, 0, 2'b11, 0, 0);
    run_slave("R7 lj ignores res", 9, 0, 0, 2'b10, 0, 0);
    check("R11 drive flag", 24'(clk_drive_o), 24'd0);

    // R10 master mode
    cfg_master = 1; cfg_rjust = 0; cfg_delay = 0; cfg_res = 2'b00;
    cfg_bclk_fall = 0; cfg_wclk_inv = 0; sdata_i = 0;
    do_reset();
    ma = 24'h3C5A96; mb = 24'hC3A569;
    pw = 0; pb = 0; slot = 0; t0 = -1; per = 0; nb = 0;
    for (int c = 0; c < 64 * 4 * 6; c++) begin
      if (bclk_o && !pb) begin
        if (t0 >= 0) per = c - t0;
        t0 = c;
        nb = nb + 1;
      end
      if (!bclk_o && pb) begin
        if (wclk_o != pw) begin
          if (c > 300 && wclk_o) check("R10 bit periods per half", 24'(nb), 24'd32);
          nb = 0;
          slot = 0;
        end else slot = slot + 1;
        pw = wclk_o;
        sdata_i = (slot < 24) ? (wclk_o ? ma[23-slot] : mb[23-slot]) : 1'b0;
      end
      pb = bclk_o;
      @(negedge clk);
    end
    check("R10 bclk period", 24'(per), 24'd4);
    check("R10 drive flag", 24'(clk_drive_o), 24'd1);
    check("R10 pairs seen", 24'(ncap >= 3), 24'd1);
    check("R10 left", cap_l[0], ma);
    check("R10 right", cap_r[0], mb);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule